// File: doc/BRIEF.md
# Wide Integer Divide/Modulo Unit

This unit divides one wide two's-complement word by another. A single request returns both the quotient and the remainder. The default width is 256 bits. An operation select picks unsigned or signed interpretation, and also picks which of the two results appears on a third, combined output. The hardware core is a restoring shift-subtract loop that settles one quotient bit per clock.

A caller presents the operands and the select, then pulses `start` while `busy` is low. The unit first turns signed operands into magnitudes. It then runs the loop and applies the result signs in a closing cycle. The corner cases of stack-machine arithmetic are resolved in hardware and raise no exception:

- A zero divisor yields zero on every result.
- The signed overflow case (most-negative dividend over minus one) yields a defined value.

When the outputs are ready, `done` pulses for one cycle. The outputs then hold steady until the next operation completes.

Top module: `divmod_unit`

## Requirements
- R1: With `op[1]`=0 (unsigned) and a nonzero divisor, `quotient` is the floor of dividend/divisor and `remainder` is dividend minus quotient times divisor, both as unsigned W-bit words.
- R2: With `op[1]`=1 (signed, two's complement) and no special case, `quotient` is truncated toward zero and `remainder` carries the sign of the dividend, with |remainder| < |divisor|.
- R3: A zero divisor makes `quotient`, `remainder` and `result` all 0, for all four `op` codes.
- R4: For signed operations, when the dividend is 1 followed by W-1 zeros and the divisor is all ones, `quotient` equals the dividend and `remainder` is 0.
- R5: `result` equals `remainder` when `op[0]`=1 and equals `quotient` when `op[0]`=0. The codes are 00 unsigned divide, 01 unsigned remainder, 10 signed divide and 11 signed remainder.
- R6: The rising edge that samples `start` with `busy` low sets `busy`. `done` rises exactly W+2 rising edges after that edge, counting it as edge 0. `busy` stays high throughout and falls on the same edge that sets `done`.
- R7: `start` and the operand inputs are ignored while `busy` is high: the running operation finishes with its captured operands, and no second operation follows.
- R8: `done` is high for exactly one cycle. `quotient`, `remainder` and `result` change only on the edge that raises `done`.
- R9: While reset is applied, `busy`, `done`, `quotient`, `remainder` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation; sampled only while `busy` is low |
| op | input | 2 | bit 1: signed; bit 0: `result` shows remainder |
| dividend | input | W | Dividend operand |
| divisor | input | W | Divisor operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: results updated |
| quotient | output | W | Quotient of the last completed operation |
| remainder | output | W | Remainder of the last completed operation |
| result | output | W | Quotient or remainder, chosen by `op[0]` |

## Verification
The internal state is a phase register, a bit counter and the partial remainder and quotient. A wrong bit counter shows up as a `done` pulse on the wrong edge. That is visible at the first completion after the fault, W+2 cycles after `start`.

A wrong borrow decision or a lost shift bit corrupts the words, but only when the sign-corrected results are written. The signed operand mixes, the zero divisor and the overflow pair each steer a different correction path. A fault on any one path shows up on the first operation that uses it.

// File: rtl/divmod_pkg.sv
package divmod_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PREP = 2'd1,
    PH_LOOP = 2'd2,
    PH_FIX  = 2'd3
  } phase_e;

  localparam int unsigned OP_SIGNED_BIT = 1;
  localparam int unsigned OP_REMSEL_BIT = 0;

endpackage

// File: rtl/divmod_prep.sv
module divmod_prep #(
  parameter int unsigned W = 256
) (
  input  logic         is_signed,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dsr,
  output logic [W-1:0] dvd_mag,
  output logic [W-1:0] dsr_mag,
  output logic         neg_quo,
  output logic         neg_rem,
  output logic         dsr_zero,
  output logic         sgn_ovf
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic dvd_neg;
  logic dsr_neg;

  always_comb begin
    dvd_neg  = is_signed & dvd[W-1];
    dsr_neg  = is_signed & dsr[W-1];
    dvd_mag  = dvd_neg ? (~dvd + 1'b1) : dvd;
    dsr_mag  = dsr_neg ? (~dsr + 1'b1) : dsr;
    neg_quo  = dvd_neg ^ dsr_neg;
    neg_rem  = dvd_neg;
    dsr_zero = (dsr == '0);
    sgn_ovf  = is_signed & (dvd == MOST_NEG) & (dsr == '1);
  end

endmodule

// File: rtl/divmod_core.sv
module divmod_core #(
  parameter int unsigned W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd_in,
  input  logic [W-1:0] dsr_in,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  logic [W-1:0] quo_q, quo_d;
  logic [W-1:0] rem_q, rem_d;
  logic [W-1:0] dsr_q;
  logic [W:0]   trial;
  logic         borrow;

  always_comb begin
    trial  = {rem_q, quo_q[W-1]} - {1'b0, dsr_q};
    borrow = trial[W];
    quo_d  = quo_q;
    rem_d  = rem_q;
    if (load) begin
      quo_d = dvd_in;
      rem_d = '0;
    end else if (step) begin
      quo_d = {quo_q[W-2:0], ~borrow};
      rem_d = borrow ? {rem_q[W-2:0], quo_q[W-1]} : trial[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dsr_q <= '0;
    end else begin
      if (load | step) begin
        quo_q <= quo_d;
        rem_q <= rem_d;
      end
      if (load) begin
        dsr_q <= dsr_in;
      end
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;

endmodule

// File: rtl/divmod_fix.sv
module divmod_fix #(
  parameter int unsigned W = 256
) (
  input  logic [W-1:0] raw_quo,
  input  logic [W-1:0] raw_rem,
  input  logic [W-1:0] dvd,
  input  logic         neg_quo,
  input  logic         neg_rem,
  input  logic         dsr_zero,
  input  logic         sgn_ovf,
  input  logic         rem_sel,
  output logic [W-1:0] quo_out,
  output logic [W-1:0] rem_out,
  output logic [W-1:0] res_out
);

  always_comb begin
    if (dsr_zero) begin
      quo_out = '0;
      rem_out = '0;
    end else if (sgn_ovf) begin
      quo_out = dvd;
      rem_out = '0;
    end else begin
      quo_out = neg_quo ? (~raw_quo + 1'b1) : raw_quo;
      rem_out = neg_rem ? (~raw_rem + 1'b1) : raw_rem;
    end
    res_out = rem_sel ? rem_out : quo_out;
  end

endmodule

// File: rtl/divmod_unit.sv
module divmod_unit
  import divmod_pkg::*;
#(
  parameter int unsigned W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic [W-1:0] result
);

  localparam int unsigned CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

  // reset synchronizer: assertion asynchronous, release on clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    op_q;
  logic [W-1:0]  dvd_q, dsr_q;
  logic          neg_quo_q, neg_rem_q, zero_q, ovf_q;
  logic [W-1:0]  quo_q, rem_q, res_q;
  logic          done_q;

  logic          accept;
  logic          core_load, core_step;
  logic [W-1:0]  dvd_mag, dsr_mag;
  logic          neg_quo_c, neg_rem_c, zero_c, ovf_c;
  logic [W-1:0]  raw_quo, raw_rem;
  logic [W-1:0]  fix_quo, fix_rem, fix_res;

  assign accept    = start & (phase_q == PH_IDLE) & rst_int_n;
  assign core_load = (phase_q == PH_PREP);
  assign core_step = (phase_q == PH_LOOP);

  // next-state
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (accept) phase_d = PH_PREP;
      PH_PREP: begin
        phase_d = PH_LOOP;
        cnt_d   = '0;
      end
      PH_LOOP: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_BIT) phase_d = PH_FIX;
      end
      PH_FIX:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= (phase_q == PH_FIX);
    end
  end

  // operand capture, enabled on accept
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_q  <= '0;
      dvd_q <= '0;
      dsr_q <= '0;
    end else if (accept) begin
      op_q  <= op;
      dvd_q <= dividend;
      dsr_q <= divisor;
    end
  end

  divmod_prep #(.W(W)) u_prep (
    .is_signed (op_q[OP_SIGNED_BIT]),
    .dvd       (dvd_q),
    .dsr       (dsr_q),
    .dvd_mag   (dvd_mag),
    .dsr_mag   (dsr_mag),
    .neg_quo   (neg_quo_c),
    .neg_rem   (neg_rem_c),
    .dsr_zero  (zero_c),
    .sgn_ovf   (ovf_c)
  );

  // sign and special-case flags, enabled in the prepare phase
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
      zero_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else if (core_load) begin
      neg_quo_q <= neg_quo_c;
      neg_rem_q <= neg_rem_c;
      zero_q    <= zero_c;
      ovf_q     <= ovf_c;
    end
  end

  divmod_core #(.W(W)) u_core (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load   (core_load),
    .step   (core_step),
    .dvd_in (dvd_mag),
    .dsr_in (dsr_mag),
    .quo    (raw_quo),
    .rem    (raw_rem)
  );

  divmod_fix #(.W(W)) u_fix (
    .raw_quo  (raw_quo),
    .raw_rem  (raw_rem),
    .dvd      (dvd_q),
    .neg_quo  (neg_quo_q),
    .neg_rem  (neg_rem_q),
    .dsr_zero (zero_q),
    .sgn_ovf  (ovf_q),
    .rem_sel  (op_q[OP_REMSEL_BIT]),
    .quo_out  (fix_quo),
    .rem_out  (fix_rem),
    .res_out  (fix_res)
  );

  // result registers, enabled in the closing phase
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      quo_q <= '0;
      rem_q <= '0;
      res_q <= '0;
    end else if (phase_q == PH_FIX) begin
      quo_q <= fix_quo;
      rem_q <= fix_rem;
      res_q <= fix_res;
    end
  end

  assign busy      = (phase_q != PH_IDLE);
  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign result    = res_q;

endmodule

// File: rtl/divmod_unit_chk.sv
module divmod_unit_chk #(
  parameter int unsigned W = 256
) (
  input logic         clk,
  input logic         rst_n,
  input logic         accept,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic [W-1:0] result
);

  localparam int unsigned NW = $clog2(W + 3) + 1;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [NW-1:0] age_q;
  logic          zero_d, ovf_d, sel_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      zero_d <= 1'b0;
      ovf_d  <= 1'b0;
      sel_d  <= 1'b0;
    end else if (accept) begin
      age_q  <= '0;
      zero_d <= (divisor == '0);
      ovf_d  <= op[1] & (dividend == MOST_NEG) & (divisor == '1);
      sel_d  <= op[0];
    end else if (busy) begin
      age_q  <= age_q + 1'b1;
    end
  end

  p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_done_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (age_q == NW'(W + 2)) && !busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(quotient) && $stable(remainder) && $stable(result));

  p_zero_divisor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_d) |-> (quotient == '0) && (remainder == '0) && (result == '0));

  p_signed_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf_d && !zero_d) |-> (quotient == MOST_NEG) && (remainder == '0));

  p_result_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result == (sel_d ? remainder : quotient)));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy || done);

endmodule

bind divmod_unit divmod_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .accept    (accept),
  .start     (start),
  .op        (op),
  .dividend  (dividend),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder),
  .result    (result)
);

// File: tb/divmod_unit_tb.sv
`timescale 1ns/1ps
module divmod_unit_tb;

  localparam int unsigned W = 256;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL1 = '1;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [1:0]   op;
  logic [W-1:0] dividend, divisor;
  logic         busy, done;
  logic [W-1:0] quotient, remainder, result;

  int n_checks;
  int n_fails;

  divmod_unit #(.W(W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .result    (result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  task automatic chk(input logic ok, input string req,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent reference from the requirements
  task automatic model(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] q, output logic [W-1:0] r);
    if (b == '0) begin
      q = '0; r = '0;
    end else if (o[1]) begin
      if (a == MOST_NEG && b == ALL1) begin
        q = a; r = '0;
      end else begin
        q = W'($signed(a) / $signed(b));
        r = W'($signed(a) % $signed(b));
      end
    end else begin
      q = a / b;
      r = a % b;
    end
  endtask

  // runs one operation; poke>0 pulses start with junk operands in that busy cycle
  task automatic run_op(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                        input string req, input int poke);
    logic bad;
    logic [W-1:0] eq, er, ex;
    @(negedge clk);
    op = o; dividend = a; divisor = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    bad = !(busy && !done);
    for (int i = 1; i <= int'(W) + 1; i++) begin
      if (i == poke) begin
        start = 1'b1; op = ~o; dividend = ~a; divisor = b + 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (!(busy && !done)) bad = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(!bad, "R6 busy high and done low before edge W+2", W'(bad), '0);
    chk(done && !busy, "R6 done at edge W+2", W'({done, busy}), W'(2'b10));
    model(o, a, b, eq, er);
    ex = o[0] ? er : eq;
    chk(quotient == eq, {req, " quotient"}, quotient, eq);
    chk(remainder == er, {req, " remainder"}, remainder, er);
    chk(result == ex, "R5 result select", result, ex);
    @(posedge clk);
    @(negedge clk);
    chk(!done, "R8 done single cycle", W'(done), '0);
    chk(quotient == eq && remainder == er && result == ex, "R8 outputs held", quotient, eq);
    if (poke > 0) chk(!busy, "R7 no queued operation", W'(busy), '0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; op = '0; dividend = '0; divisor = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done, "R9 reset busy/done", W'({busy, done}), '0);
    chk(quotient == '0 && remainder == '0 && result == '0, "R9 reset results", quotient, '0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_unsigned();
    run_op(2'b00, W'(100), W'(7), "R1 udiv small", 0);
    run_op(2'b01, ALL1, W'(3), "R1 umod all-ones", 0);
    run_op(2'b00, W'(5), ALL1, "R1 dividend below divisor", 0);
    run_op(2'b01, MOST_NEG | W'(12345), W'(1), "R1 divide by one", 0);
    run_op(2'b00, {W/2{2'b10}}, {1'b0, {(W-1){1'b1}}} >> 7, "R1 wide pattern", 0);
  endtask

  task automatic t_signed();
    run_op(2'b10, -W'(7), W'(2), "R2 neg/pos", 0);
    run_op(2'b11, W'(7), -W'(2), "R2 pos/neg", 0);
    run_op(2'b11, -W'(7), -W'(2), "R2 neg/neg", 0);
    run_op(2'b10, MOST_NEG, W'(1), "R2 most-negative over one", 0);
    run_op(2'b11, MOST_NEG, W'(3), "R2 most-negative mod three", 0);
  endtask

  task automatic t_zero_div();
    for (int k = 0; k < 4; k++) run_op(2'(k), MOST_NEG | W'(77), '0, "R3 zero divisor", 0);
  endtask

  task automatic t_overflow();
    run_op(2'b10, MOST_NEG, ALL1, "R4 signed overflow quotient", 0);
    run_op(2'b11, MOST_NEG, ALL1, "R4 signed overflow remainder", 0);
    run_op(2'b00, MOST_NEG, ALL1, "R1 same pair unsigned", 0);
  endtask

  task automatic t_ignore();
    run_op(2'b00, W'(1000), W'(9), "R7 start ignored while busy", 5);
    run_op(2'b11, -W'(50), W'(6), "R7 start ignored near end", int'(W) + 1);
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    t_reset();
    t_unsigned();
    t_signed();
    t_zero_div();
    t_overflow();
    t_ignore();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

endmodule